// File: doc/BRIEF.md
# Dual-Class Interrupt Priority Resolver

This block takes the pending, mask, routing and priority state of a set of interrupt line banks and picks a winner for each of two service classes. The two classes are a normal class and a fast class. A line takes part in the search for a class only when it is pending, not masked, and routed to that class. Among the lines taking part, the smallest priority value wins. When two lines share a priority value, the higher-numbered line wins.

The search covers one bank per clock. After the last bank it evaluates each class. An armed class with a winner, while the global enable is on, latches the winner code, raises its request line and pulses its done strobe. The class then stays disarmed. The register block re-arms a class with a one-cycle re-arm pulse. That pulse drops the class's request and restarts the search, so the outstanding state is evaluated again at once.

Top module: `irq_arbiter_dual`

## Requirements
- R1: A line is eligible for a class only when its pending bit is 1 and its mask bit is 0. It goes to the fast class when its route bit is 1 and to the normal class when its route bit is 0. Lines of the other class never affect a class's result.
- R2: Among the eligible lines of a class, the line with the numerically smallest 6-bit priority value wins. Value 0 is the most urgent.
- R3: When eligible lines of a class share the smallest priority value, the highest-numbered line wins. This holds across bank boundaries as well.
- R4: The winner code is 32 × bank + bit index, which is the flat line number 0 to 95 in the default configuration.
- R5: A class's request rises only when that class is armed, it has an eligible line, and the global enable is 1. In that same cycle the winner code is latched, the done strobe pulses for one cycle, and the class is disarmed.
- R6: A re-arm pulse for a class drives that class's request low on the next cycle and arms the class again. A fresh evaluation then completes within 2 × NBANK + 2 cycles.
- R7: When a class has no eligible line, its request stays low and its latched code keeps its previous value.
- R8: After reset both requests are low, both codes are 0, and both classes are armed.
- R9: While a class is disarmed, changes to the inputs change neither its request nor its code.
- R10: A re-arm pulse for one class leaves the request and code of the other class unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | NBANK*LPB | Pending bit per line |
| mask_i | input | NBANK*LPB | Mask bit per line, 1 = masked |
| route_i | input | NBANK*LPB | Class select per line, 1 = fast, 0 = normal |
| prio_i | input | NBANK*LPB*PW | Priority per line, line n at bits n*PW upward |
| glb_en_i | input | 1 | Global enable for raising requests |
| rearm_i | input | 2 | Re-arm pulse: bit 0 normal class, bit 1 fast class |
| norm_req_o | output | 1 | Normal-class request |
| fast_req_o | output | 1 | Fast-class request |
| norm_done_o | output | 1 | One-cycle strobe when the normal code is latched |
| fast_done_o | output | 1 | One-cycle strobe when the fast code is latched |
| norm_code_o | output | CW | Latched normal-class winner |
| fast_code_o | output | CW | Latched fast-class winner |

## Verification
The hardest case to reach is a priority tie split across two banks. The winner must then come from the later bank, even though the earlier bank's candidate was already stored. A pseudo-random sweep draws priorities from only four values, so such split ties happen often, and every draw is compared with a flat scan over all 96 lines computed in the bench. The disarmed state is reached by changing inputs after a request without re-arming. The gated state is reached by re-arming while the global enable is low and raising the enable later.

// File: rtl/irq_arbiter_dual.sv
module irq_arbiter_dual #(
  parameter int NBANK = 3,
  parameter int LPB = 32,
  parameter int PW = 6,
  localparam int CW = $clog2(NBANK * LPB)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBANK*LPB-1:0]    pend_i,
  input  logic [NBANK*LPB-1:0]    mask_i,
  input  logic [NBANK*LPB-1:0]    route_i,
  input  logic [NBANK*LPB*PW-1:0] prio_i,
  input  logic                    glb_en_i,
  input  logic [1:0]              rearm_i,
  output logic                    norm_req_o,
  output logic                    fast_req_o,
  output logic                    norm_done_o,
  output logic                    fast_done_o,
  output logic [CW-1:0]           norm_code_o,
  output logic [CW-1:0]           fast_code_o
);
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int LAST = NBANK - 1;

  logic [BW-1:0] cnt;
  logic [1:0]    armed, req, done, acc_v, bv, mv;
  logic [PW-1:0] acc_p [2];
  logic [PW-1:0] bp [2];
  logic [PW-1:0] mp [2];
  logic [CW-1:0] acc_c [2];
  logic [CW-1:0] bc [2];
  logic [CW-1:0] mc [2];
  logic [CW-1:0] code_q [2];

  always_comb begin
    int ln;
    logic [PW-1:0] p;
    for (int c = 0; c < 2; c++) begin
      bv[c] = 1'b0;
      bp[c] = '0;
      bc[c] = '0;
      for (int i = 0; i < LPB; i++) begin
        ln = int'(cnt) * LPB + i;
        p  = prio_i[ln*PW +: PW];
        if (pend_i[ln] && !mask_i[ln] && (route_i[ln] == (c == 1)) &&
            (!bv[c] || p <= bp[c])) begin
          bv[c] = 1'b1;
          bp[c] = p;
          bc[c] = CW'(ln);
        end
      end
      mv[c] = acc_v[c] | bv[c];
      if (bv[c] && (!acc_v[c] || bp[c] <= acc_p[c])) begin
        mp[c] = bp[c];
        mc[c] = bc[c];
      end else begin
        mp[c] = acc_p[c];
        mc[c] = acc_c[c];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 2'b11;
      req   <= 2'b00;
      done  <= 2'b00;
      acc_v <= 2'b00;
      for (int c = 0; c < 2; c++) begin
        acc_p[c]  <= '0;
        acc_c[c]  <= '0;
        code_q[c] <= '0;
      end
    end else begin
      done <= 2'b00;
      for (int c = 0; c < 2; c++) begin
        if (rearm_i[c]) begin
          req[c]   <= 1'b0;
          armed[c] <= 1'b1;
        end
      end
      if (|rearm_i) begin
        cnt   <= '0;
        acc_v <= 2'b00;
      end else if (int'(cnt) == LAST) begin
        cnt   <= '0;
        acc_v <= 2'b00;
        for (int c = 0; c < 2; c++) begin
          if (armed[c] && mv[c] && glb_en_i) begin
            req[c]    <= 1'b1;
            armed[c]  <= 1'b0;
            code_q[c] <= mc[c];
            done[c]   <= 1'b1;
          end
        end
      end else begin
        cnt   <= cnt + 1'b1;
        acc_v <= mv;
        for (int c = 0; c < 2; c++) begin
          acc_p[c] <= mp[c];
          acc_c[c] <= mc[c];
        end
      end
    end
  end

  assign norm_req_o  = req[0];
  assign fast_req_o  = req[1];
  assign norm_done_o = done[0];
  assign fast_done_o = done[1];
  assign norm_code_o = code_q[0];
  assign fast_code_o = code_q[1];
endmodule

// File: rtl/irq_arbiter_dual_chk.sv
module irq_arbiter_dual_chk #(
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          glb_en_i,
  input logic [1:0]    rearm_i,
  input logic          norm_req_o,
  input logic          fast_req_o,
  input logic          norm_done_o,
  input logic          fast_done_o,
  input logic [CW-1:0] norm_code_o,
  input logic [CW-1:0] fast_code_o
);
  assert_norm_rise_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(norm_req_o) |-> norm_done_o);
  assert_fast_rise_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_req_o) |-> fast_done_o);
  assert_done_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (norm_done_o || fast_done_o) |-> $past(glb_en_i));
  assert_norm_rearm_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i[0] |=> !norm_req_o);
  assert_fast_rearm_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i[1] |=> !fast_req_o);
  assert_norm_fall_only_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(norm_req_o) |-> $past(rearm_i[0]));
  assert_fast_fall_only_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fast_req_o) |-> $past(rearm_i[1]));
  assert_norm_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !norm_done_o |-> $stable(norm_code_o));
  assert_fast_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_done_o |-> $stable(fast_code_o));
endmodule

bind irq_arbiter_dual irq_arbiter_dual_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en_i), .rearm_i(rearm_i),
  .norm_req_o(norm_req_o), .fast_req_o(fast_req_o),
  .norm_done_o(norm_done_o), .fast_done_o(fast_done_o),
  .norm_code_o(norm_code_o), .fast_code_o(fast_code_o)
);

// File: tb/irq_arbiter_dual_tb.sv
`timescale 1ns/1ps
module irq_arbiter_dual_tb;
  localparam int NB = 3;
  localparam int NL = NB * 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] pend = '0, msk = '0, rt = '0;
  logic [5:0] pr [NL];
  logic [NL*6-1:0] prio_v;
  logic glb_en = 1'b1;
  logic [1:0] rearm = 2'b00;
  logic nreq, freq, ndone, fdone;
  logic [6:0] ncode, fcode;

  int chk = 0, err = 0;
  int exp_code [2];
  bit seen [2];
  logic [31:0] rs = 32'h1234_5678;

  always #4 clk = ~clk;

  always_comb
    for (int l = 0; l < NL; l++) prio_v[l*6 +: 6] = pr[l];

  irq_arbiter_dual u_dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(msk), .route_i(rt),
    .prio_i(prio_v), .glb_en_i(glb_en), .rearm_i(rearm),
    .norm_req_o(nreq), .fast_req_o(freq), .norm_done_o(ndone),
    .fast_done_o(fdone), .norm_code_o(ncode), .fast_code_o(fcode)
  );

  function automatic logic [31:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic int get_req(int c);
    return c == 1 ? int'(freq) : int'(nreq);
  endfunction

  function automatic int get_code(int c);
    return c == 1 ? int'(fcode) : int'(ncode);
  endfunction

  task automatic check(string tag, int got, int exp);
    chk++;
    if (got != exp) begin
      err++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Flat reference: smallest value wins, highest line on a tie (R1 R2 R3 R4)
  task automatic model(int c, output bit v, output int code);
    int bp;
    v = 0; code = 0; bp = 0;
    for (int l = 0; l < NL; l++)
      if (pend[l] && !msk[l] && (int'(rt[l]) == c) && (!v || int'(pr[l]) <= bp)) begin
        v = 1; bp = int'(pr[l]); code = l;
      end
  endtask

  task automatic settle();
    seen[0] = 0; seen[1] = 0;
    repeat (2 * NB + 2) begin
      @(negedge clk);
      if (ndone) seen[0] = 1;
      if (fdone) seen[1] = 1;
    end
  endtask

  task automatic pulse(logic [1:0] m);
    @(negedge clk) rearm = m;
    @(negedge clk) rearm = 2'b00;
    for (int c = 0; c < 2; c++)
      if (m[c]) check("R6 request low after re-arm", get_req(c), 0);
  endtask

  task automatic evaluate(string tag);
    bit v;
    int code;
    pulse(2'b11);
    settle();
    for (int c = 0; c < 2; c++) begin
      model(c, v, code);
      if (v) begin
        exp_code[c] = code;
        check({tag, " R5 done strobe"}, int'(seen[c]), 1);
        check({tag, " R5 request"}, get_req(c), 1);
        check({tag, " R2 R3 R4 code"}, get_code(c), code);
      end else begin
        check({tag, " R7 request low"}, get_req(c), 0);
        check({tag, " R7 code held"}, get_code(c), exp_code[c]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    err++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chk, err);
    $finish;
  end

  initial begin
    for (int l = 0; l < NL; l++) pr[l] = '0;
    exp_code[0] = 0; exp_code[1] = 0;
    repeat (3) @(negedge clk);
    check("R8 reset normal request", int'(nreq), 0);
    check("R8 reset fast request", int'(freq), 0);
    check("R8 reset normal code", int'(ncode), 0);
    check("R8 reset fast code", int'(fcode), 0);
    rst_n = 1'b1;
    // R8: both classes armed, so a pending line raises without re-arm
    @(negedge clk) begin pend[7] = 1; pend[40] = 1; rt[40] = 1; end
    settle();
    check("R8 armed normal", int'(nreq), 1);
    check("R8 armed fast", int'(freq), 1);
    check("R8 R4 normal code", int'(ncode), 7);
    check("R8 R4 fast code", int'(fcode), 40);
    exp_code[0] = 7; exp_code[1] = 40;

    // R1 R4: each single line in turn, alternating class
    for (int l = 0; l < NL; l++) begin
      pend = '0; msk = '0; rt = '0;
      pend[l] = 1; rt[l] = l[0];
      pr[l] = 6'(l % 64);
      evaluate("R1 single line");
    end

    // R1: masked line excluded, other class keeps its result
    pend = '0; rt = '0; msk = '0;
    pend[10] = 1; pend[20] = 1; msk[20] = 1; pr[10] = 9; pr[20] = 0;
    evaluate("R1 masked line");
    check("R1 masked winner", int'(ncode), 10);

    // R3: all lines pending at equal priority go to the top line
    for (int l = 0; l < NL; l++) pr[l] = 6'd3;
    pend = '1; msk = '0; rt = '0;
    evaluate("R3 full tie");
    check("R3 top line", int'(ncode), NL - 1);

    // R3: tie across banks, lower bank line must lose
    pend = '0; pend[31] = 1; pend[33] = 1; pr[31] = 1; pr[33] = 1;
    evaluate("R3 bank tie");
    check("R3 later bank", int'(ncode), 33);

    // R2 R3: pseudo-random sweep with few priority values
    for (int k = 0; k < 150; k++) begin
      for (int w = 0; w < NB; w++) begin
        pend[w*32 +: 32] = rnd() & rnd();
        msk[w*32 +: 32]  = rnd() & rnd();
        rt[w*32 +: 32]   = rnd();
      end
      for (int l = 0; l < NL; l++) pr[l] = 6'(rnd() % 4);
      evaluate("R2 sweep");
    end

    // R7: everything masked
    pend = '1; msk = '1;
    evaluate("R7 all masked");

    // R5: global enable gates raising; class stays armed
    msk = '0; pend = '0; rt = '0; pend[50] = 1; pend[60] = 1; rt[60] = 1;
    glb_en = 1'b0;
    pulse(2'b11);
    settle();
    check("R5 gated normal", int'(nreq), 0);
    check("R5 gated no done", int'(seen[0]), 0);
    glb_en = 1'b1;
    settle();
    check("R5 enabled normal", int'(nreq), 1);
    check("R5 enabled code", int'(ncode), 50);
    check("R5 enabled fast", int'(fcode), 60);

    // R9: disarmed, a better line appears
    pend[70] = 1; pr[70] = 0; pr[50] = 5;
    settle();
    check("R9 code unchanged", int'(ncode), 50);
    check("R9 request unchanged", int'(nreq), 1);
    check("R9 no done", int'(seen[0]), 0);

    // R10: re-arm normal only
    pulse(2'b01);
    settle();
    check("R10 fast request kept", int'(freq), 1);
    check("R10 fast code kept", int'(fcode), 60);
    check("R6 normal re-evaluated", int'(ncode), 70);
    check("R6 normal raised", int'(nreq), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chk, err);
    $finish;
  end
endmodule